// File: doc/BRIEF.md
# Per-Port Bus Access Guard

This block sits between one bus manager and a set of peripheral ports. It checks every request against two per-port rules and either forwards the request or answers it locally. Each request carries a port index, a security attribute (secure or non-secure) and a privilege attribute (privileged or unprivileged). Wires from elsewhere in the chip supply the per-port configuration: whether a port is reserved for non-secure traffic, and whether it admits unprivileged traffic. A build-time mask can exempt chosen ports from the security comparison. A build-time map can mark ports as having no downstream path. Such a port keeps its index, and every access to it fails.

A refused request is answered one cycle after it is accepted, and nothing is presented on any downstream port. A global select bit chooses the answer. With the bit set, the answer is a bus error. With the bit clear, the answer is an OK response with zero read data, and a write is dropped. Each refusal raises a sticky violation flag. An enable input gates the flag onto a level interrupt. A clear input wipes the flag and stops it from capturing new refusals for as long as the input is held.

The block handles one transaction at a time. It accepts a request with a valid/ready handshake, presents an allowed request to a single port with a valid/ready handshake, waits for that port's response and returns it upstream for one cycle.

Top module: `periph_guard`

## Requirements
- R1: After reset, `up_ready_o` is 1, `up_rvalid_o` is 0, `dn_valid_o` is all zero and `irq_o` is 0. All captured configuration is zero.
- R2: The configuration and control inputs (`cfg_ns_i`, `cfg_upriv_i`, `cfg_err_i`, `irq_en_i`, `irq_clr_i`) are captured into registers at every clock edge. A request accepted at an edge is judged by the values captured at the previous edge.
- R3: A request to port n is refused when `up_secure_i` equals captured `cfg_ns_i[n]` and bit n of `NS_MASK` is 0. A secure request to a non-secure port is refused, and so is a non-secure request to a secure port.
- R4: When bit n of `NS_MASK` is 1, the security comparison never refuses a request to port n.
- R5: A request with `up_user_i`=1 to port n is refused when captured `cfg_upriv_i[n]` is 0, whatever the security rule gives.
- R6: An allowed request raises `dn_valid_o[n]` only for the selected port. It drives `dn_addr_o`, `dn_write_o` and `dn_wdata_o` and holds all of them stable until `dn_ready_i[n]`. The data and error that the port returns with `dn_rvalid_i[n]` appear on `up_rdata_o`/`up_err_o` with `up_rvalid_o` one cycle later.
- R7: With captured `cfg_err_i`=1, a refused request gets `up_rvalid_o`=1, `up_err_o`=1 and `up_rdata_o`=0 in the cycle after acceptance, and no `dn_valid_o` bit rises.
- R8: With captured `cfg_err_i`=0, a refused read or write gets `up_rvalid_o`=1, `up_err_o`=0 and `up_rdata_o`=0 in the cycle after acceptance, and no `dn_valid_o` bit rises.
- R9: A request to a port whose `CONNECTED` bit is 0, or whose index is not below `N_PORTS`, gets an error response in the cycle after acceptance, whatever `cfg_err_i` is. It is not forwarded and it does not set the violation flag.
- R10: A refused request (R3 or R5) sets the sticky violation flag when captured `irq_clr_i` is 0. The flag stays set until it is cleared.
- R11: While captured `irq_clr_i` is 1, the flag is cleared and refusals are not recorded. Clear takes priority over a refusal in the same cycle.
- R12: `irq_o` equals the violation flag AND captured `irq_en_i`.
- R13: `up_ready_o` is 1 only while no transaction is in flight. It is 0 from acceptance until the response cycle ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ns_i | input | N_PORTS | Per-port non-secure setting |
| cfg_upriv_i | input | N_PORTS | Per-port unprivileged-access permission |
| cfg_err_i | input | 1 | 1: refused requests get a bus error; 0: silent OK |
| irq_en_i | input | 1 | Interrupt enable |
| irq_clr_i | input | 1 | Violation flag clear (level) |
| irq_o | output | 1 | Violation interrupt |
| up_valid_i | input | 1 | Upstream request valid |
| up_ready_o | output | 1 | Upstream request ready |
| up_port_i | input | PORT_W | Target port index |
| up_write_i | input | 1 | 1 for write |
| up_addr_i | input | ADDR_W | Address within the port |
| up_wdata_i | input | DATA_W | Write data |
| up_secure_i | input | 1 | Security attribute (1 = secure) |
| up_user_i | input | 1 | Privilege attribute (1 = unprivileged) |
| up_rvalid_o | output | 1 | Upstream response valid |
| up_rdata_o | output | DATA_W | Response read data |
| up_err_o | output | 1 | Response error |
| dn_valid_o | output | N_PORTS | Per-port request valid |
| dn_ready_i | input | N_PORTS | Per-port request ready |
| dn_write_o | output | 1 | Forwarded write flag |
| dn_addr_o | output | ADDR_W | Forwarded address |
| dn_wdata_o | output | DATA_W | Forwarded write data |
| dn_rvalid_i | input | N_PORTS | Per-port response valid |
| dn_rdata_i | input | N_PORTS*DATA_W | Per-port read data, port n at bits n*DATA_W upward |
| dn_err_i | input | N_PORTS | Per-port response error |

## Verification
A refusal and a clear can land on the same edge. The flag must then end up clear, and the refusal must not be recorded. The bench holds the clear input high, issues a refused request while it is held, and checks that the interrupt stays low once the enable is up. A configuration change and a request can also share an edge. The bench presents a new non-secure setting together with a request to that port and expects the verdict under the old setting. Every refusal's timing, answer and interrupt effect are judged against a behavioural model that tracks the captured inputs and the flag on each clock.

// File: rtl/periph_guard_pkg.sv
package periph_guard_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FWD,
        ST_WAIT,
        ST_RESP
    } pg_state_e;

    typedef enum logic [1:0] {
        DEC_PASS,
        DEC_BLOCK,
        DEC_NOPATH
    } pg_dec_e;

    function automatic pg_dec_e pg_classify(input logic no_path, input logic refused);
        if (no_path)      return DEC_NOPATH;
        else if (refused) return DEC_BLOCK;
        else              return DEC_PASS;
    endfunction

endpackage

// File: rtl/pg_cfg_bank.sv
module pg_cfg_bank #(
    parameter int N_PORTS = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_PORTS-1:0] ns_i,
    input  logic [N_PORTS-1:0] upriv_i,
    input  logic               err_sel_i,
    input  logic               en_i,
    input  logic               clr_i,
    input  logic               viol_i,
    output logic [N_PORTS-1:0] ns_q,
    output logic [N_PORTS-1:0] upriv_q,
    output logic               err_sel_q,
    output logic               irq_o
);
    logic en_q;
    logic clr_q;
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ns_q      <= '0;
            upriv_q   <= '0;
            err_sel_q <= 1'b0;
            en_q      <= 1'b0;
            clr_q     <= 1'b0;
        end else begin
            ns_q      <= ns_i;
            upriv_q   <= upriv_i;
            err_sel_q <= err_sel_i;
            en_q      <= en_i;
            clr_q     <= clr_i;
        end
    end

    // sticky flag; the held clear wins over a refusal in the same cycle
    always_ff @(posedge clk) begin
        if (rst)         flag_q <= 1'b0;
        else if (clr_q)  flag_q <= 1'b0;
        else if (viol_i) flag_q <= 1'b1;
    end

    assign irq_o = flag_q & en_q;
endmodule

// File: rtl/pg_rule.sv
module pg_rule
    import periph_guard_pkg::*;
#(
    parameter int               N_PORTS   = 16,
    parameter logic [N_PORTS-1:0] NS_MASK   = '0,
    parameter logic [N_PORTS-1:0] CONNECTED = '1,
    localparam int              PORT_W    = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
    input  logic [PORT_W-1:0]  port_i,
    input  logic               secure_i,
    input  logic               user_i,
    input  logic [N_PORTS-1:0] ns_q,
    input  logic [N_PORTS-1:0] upriv_q,
    output pg_dec_e            dec_o
);
    logic [N_PORTS-1:0] hit;
    logic [N_PORTS-1:0] refuse_vec;

    for (genvar g = 0; g < N_PORTS; g++) begin : g_port
        logic sec_fail;
        logic priv_fail;
        assign hit[g]        = (port_i == PORT_W'(g));
        assign sec_fail      = (secure_i == ns_q[g]) && !NS_MASK[g];
        assign priv_fail     = user_i && !upriv_q[g];
        assign refuse_vec[g] = sec_fail | priv_fail;
    end

    assign dec_o = pg_classify(~|(hit & CONNECTED), |(hit & refuse_vec));
endmodule

// File: rtl/pg_seq.sv
module pg_seq
    import periph_guard_pkg::*;
#(
    parameter int N_PORTS = 16,
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    localparam int PORT_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  pg_dec_e                   dec_i,
    input  logic                      err_sel_q,
    output logic                      viol_o,
    input  logic                      up_valid_i,
    output logic                      up_ready_o,
    input  logic [PORT_W-1:0]         up_port_i,
    input  logic                      up_write_i,
    input  logic [ADDR_W-1:0]         up_addr_i,
    input  logic [DATA_W-1:0]         up_wdata_i,
    output logic                      up_rvalid_o,
    output logic [DATA_W-1:0]         up_rdata_o,
    output logic                      up_err_o,
    output logic [N_PORTS-1:0]        dn_valid_o,
    input  logic [N_PORTS-1:0]        dn_ready_i,
    output logic                      dn_write_o,
    output logic [ADDR_W-1:0]         dn_addr_o,
    output logic [DATA_W-1:0]         dn_wdata_o,
    input  logic [N_PORTS-1:0]        dn_rvalid_i,
    input  logic [N_PORTS*DATA_W-1:0] dn_rdata_i,
    input  logic [N_PORTS-1:0]        dn_err_i
);
    typedef struct packed {
        logic [PORT_W-1:0] port;
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } req_t;

    pg_state_e         state_q;
    req_t              req_q;
    logic [DATA_W-1:0] rdata_q;
    logic              err_q;
    logic              accept;

    assign accept = up_valid_i && (state_q == ST_IDLE);
    assign viol_o = accept && (dec_i == DEC_BLOCK);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            req_q   <= '0;
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (accept) begin
                    req_q   <= '{port: up_port_i, write: up_write_i,
                                 addr: up_addr_i, wdata: up_wdata_i};
                    rdata_q <= '0;
                    case (dec_i)
                        DEC_PASS:  state_q <= ST_FWD;
                        DEC_BLOCK: begin state_q <= ST_RESP; err_q <= err_sel_q; end
                        default:   begin state_q <= ST_RESP; err_q <= 1'b1;      end
                    endcase
                end
                ST_FWD:  if (dn_ready_i[req_q.port]) state_q <= ST_WAIT;
                ST_WAIT: if (dn_rvalid_i[req_q.port]) begin
                    state_q <= ST_RESP;
                    rdata_q <= dn_rdata_i[req_q.port*DATA_W +: DATA_W];
                    err_q   <= dn_err_i[req_q.port];
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    for (genvar g = 0; g < N_PORTS; g++) begin : g_dn
        assign dn_valid_o[g] = (state_q == ST_FWD) && (req_q.port == PORT_W'(g));
    end

    assign up_ready_o  = (state_q == ST_IDLE);
    assign up_rvalid_o = (state_q == ST_RESP);
    assign up_rdata_o  = rdata_q;
    assign up_err_o    = err_q;
    assign dn_write_o  = req_q.write;
    assign dn_addr_o   = req_q.addr;
    assign dn_wdata_o  = req_q.wdata;
endmodule

// File: rtl/periph_guard.sv
module periph_guard
    import periph_guard_pkg::*;
#(
    parameter int               N_PORTS   = 16,
    parameter int               ADDR_W    = 12,
    parameter int               DATA_W    = 32,
    parameter logic [N_PORTS-1:0] NS_MASK   = '0,
    parameter logic [N_PORTS-1:0] CONNECTED = '1,
    localparam int              PORT_W    = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N_PORTS-1:0]        cfg_ns_i,
    input  logic [N_PORTS-1:0]        cfg_upriv_i,
    input  logic                      cfg_err_i,
    input  logic                      irq_en_i,
    input  logic                      irq_clr_i,
    output logic                      irq_o,
    input  logic                      up_valid_i,
    output logic                      up_ready_o,
    input  logic [PORT_W-1:0]         up_port_i,
    input  logic                      up_write_i,
    input  logic [ADDR_W-1:0]         up_addr_i,
    input  logic [DATA_W-1:0]         up_wdata_i,
    input  logic                      up_secure_i,
    input  logic                      up_user_i,
    output logic                      up_rvalid_o,
    output logic [DATA_W-1:0]         up_rdata_o,
    output logic                      up_err_o,
    output logic [N_PORTS-1:0]        dn_valid_o,
    input  logic [N_PORTS-1:0]        dn_ready_i,
    output logic                      dn_write_o,
    output logic [ADDR_W-1:0]         dn_addr_o,
    output logic [DATA_W-1:0]         dn_wdata_o,
    input  logic [N_PORTS-1:0]        dn_rvalid_i,
    input  logic [N_PORTS*DATA_W-1:0] dn_rdata_i,
    input  logic [N_PORTS-1:0]        dn_err_i
);
    logic [N_PORTS-1:0] ns_q;
    logic [N_PORTS-1:0] upriv_q;
    logic               err_sel_q;
    logic               viol;
    pg_dec_e            dec;

    pg_cfg_bank #(.N_PORTS(N_PORTS)) u_cfg (
        .clk(clk), .rst(rst),
        .ns_i(cfg_ns_i), .upriv_i(cfg_upriv_i), .err_sel_i(cfg_err_i),
        .en_i(irq_en_i), .clr_i(irq_clr_i), .viol_i(viol),
        .ns_q(ns_q), .upriv_q(upriv_q), .err_sel_q(err_sel_q), .irq_o(irq_o)
    );

    pg_rule #(.N_PORTS(N_PORTS), .NS_MASK(NS_MASK), .CONNECTED(CONNECTED)) u_rule (
        .port_i(up_port_i), .secure_i(up_secure_i), .user_i(up_user_i),
        .ns_q(ns_q), .upriv_q(upriv_q), .dec_o(dec)
    );

    pg_seq #(.N_PORTS(N_PORTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst(rst), .dec_i(dec), .err_sel_q(err_sel_q), .viol_o(viol),
        .up_valid_i(up_valid_i), .up_ready_o(up_ready_o), .up_port_i(up_port_i),
        .up_write_i(up_write_i), .up_addr_i(up_addr_i), .up_wdata_i(up_wdata_i),
        .up_rvalid_o(up_rvalid_o), .up_rdata_o(up_rdata_o), .up_err_o(up_err_o),
        .dn_valid_o(dn_valid_o), .dn_ready_i(dn_ready_i), .dn_write_o(dn_write_o),
        .dn_addr_o(dn_addr_o), .dn_wdata_o(dn_wdata_o), .dn_rvalid_i(dn_rvalid_i),
        .dn_rdata_i(dn_rdata_i), .dn_err_i(dn_err_i)
    );
endmodule

// File: rtl/periph_guard_chk.sv
module periph_guard_chk #(
    parameter int               N_PORTS   = 16,
    parameter int               ADDR_W    = 12,
    parameter int               DATA_W    = 32,
    parameter logic [N_PORTS-1:0] CONNECTED = '1,
    localparam int              PORT_W    = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
    input logic               clk,
    input logic               rst,
    input logic               irq_en_i,
    input logic               irq_clr_i,
    input logic               irq_o,
    input logic               up_valid_i,
    input logic               up_ready_o,
    input logic [PORT_W-1:0]  up_port_i,
    input logic               up_rvalid_o,
    input logic [DATA_W-1:0]  up_rdata_o,
    input logic               up_err_o,
    input logic [N_PORTS-1:0] dn_valid_o,
    input logic [N_PORTS-1:0] dn_ready_i,
    input logic [ADDR_W-1:0]  dn_addr_o
);
    logic nopath;
    always_comb begin
        nopath = 1'b1;
        for (int k = 0; k < N_PORTS; k++)
            if (up_port_i == PORT_W'(k)) nopath = !CONNECTED[k];
    end

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> up_ready_o && !up_rvalid_o && (dn_valid_o == '0) && !irq_o);

    assert_single_target_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dn_valid_o));

    assert_hold_request_R6: assert property (@(posedge clk) disable iff (rst)
        (|dn_valid_o) && !(|(dn_valid_o & dn_ready_i)) |=> $stable(dn_valid_o) && $stable(dn_addr_o));

    // only a locally answered request completes one cycle after acceptance
    assert_local_zero_data_R7: assert property (@(posedge clk) disable iff (rst)
        $past(up_valid_i && up_ready_o) && up_rvalid_o |-> up_rdata_o == '0);

    assert_nopath_error_R9: assert property (@(posedge clk) disable iff (rst)
        up_valid_i && up_ready_o && nopath |=> up_rvalid_o && up_err_o);

    assert_clear_wins_R11: assert property (@(posedge clk) disable iff (rst)
        $past(irq_clr_i) |=> !irq_o);

    assert_irq_gated_R12: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> $past(irq_en_i));

    assert_busy_not_ready_R13: assert property (@(posedge clk) disable iff (rst)
        (up_rvalid_o || (|dn_valid_o)) |-> !up_ready_o);
endmodule

bind periph_guard periph_guard_chk #(
    .N_PORTS(N_PORTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CONNECTED(CONNECTED)
) u_chk (.*);

// File: tb/periph_guard_test.sv
module periph_guard_test;
    localparam int CLK_PERIOD = 10;
    localparam int N = 16;
    localparam logic [N-1:0] MASK = 16'h0008;
    localparam logic [N-1:0] CONN = 16'hFFDF;
    localparam int ERR_PORT = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N-1:0] ns_in = '0, ap_in = '0;
    logic err_in = 1'b0, en_in = 1'b0, clr_in = 1'b0;
    logic up_valid = 1'b0, up_write = 1'b0, up_secure = 1'b0, up_user = 1'b0;
    logic [3:0] up_port = '0;
    logic [11:0] up_addr = '0;
    logic [31:0] up_wdata = '0;
    logic [N-1:0] dn_ready = '1, dn_rvalid = '0, dn_err = '0;
    logic [N*32-1:0] dn_rdata = '0;
    logic irq_o, up_ready_o, up_rvalid_o, up_err_o, dn_write_o;
    logic [31:0] up_rdata_o, dn_wdata_o;
    logic [11:0] dn_addr_o;
    logic [N-1:0] dn_valid_o;

    int checks = 0, errors = 0;

    periph_guard #(.N_PORTS(N), .ADDR_W(12), .DATA_W(32), .NS_MASK(MASK), .CONNECTED(CONN)) uut (
        .clk(clk), .rst(rst), .cfg_ns_i(ns_in), .cfg_upriv_i(ap_in), .cfg_err_i(err_in),
        .irq_en_i(en_in), .irq_clr_i(clr_in), .irq_o(irq_o),
        .up_valid_i(up_valid), .up_ready_o(up_ready_o), .up_port_i(up_port),
        .up_write_i(up_write), .up_addr_i(up_addr), .up_wdata_i(up_wdata),
        .up_secure_i(up_secure), .up_user_i(up_user), .up_rvalid_o(up_rvalid_o),
        .up_rdata_o(up_rdata_o), .up_err_o(up_err_o), .dn_valid_o(dn_valid_o),
        .dn_ready_i(dn_ready), .dn_write_o(dn_write_o), .dn_addr_o(dn_addr_o),
        .dn_wdata_o(dn_wdata_o), .dn_rvalid_i(dn_rvalid), .dn_rdata_i(dn_rdata),
        .dn_err_i(dn_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural model of captured inputs and the violation flag
    logic [N-1:0] m_ns = '0, m_ap = '0;
    logic m_err = 1'b0, m_en = 1'b0, m_clr = 1'b0, m_flag = 1'b0;
    wire  m_irq = m_flag & m_en;

    function automatic int verdict(input int p, input bit sec, input bit usr);
        if (p >= N || !CONN[p]) return 2;
        if ((sec == m_ns[p]) && !MASK[p]) return 1;
        if (usr && !m_ap[p]) return 1;
        return 0;
    endfunction

    function automatic logic [31:0] rd_pattern(input int p, input logic [11:0] a);
        return 32'hA500_0000 | (32'(p) << 16) | 32'(a);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ns <= '0; m_ap <= '0; m_err <= 0; m_en <= 0; m_clr <= 0; m_flag <= 0;
        end else begin
            m_ns <= ns_in; m_ap <= ap_in; m_err <= err_in; m_en <= en_in; m_clr <= clr_in;
            if (m_clr) m_flag <= 1'b0;
            else if (up_valid && up_ready_o && verdict(int'(up_port), up_secure, up_user) == 1)
                m_flag <= 1'b1;
        end
    end

    // downstream responder: optional stall, answers one cycle after handshake
    int stall_req = 0, stall_cnt = 0, dv_seen = 0, fwd_count = 0;
    bit pend = 0;
    int pend_port = 0;
    logic [11:0] pend_addr = '0;
    int seen_port = -1;
    logic seen_write = 0;
    logic [31:0] seen_wdata = '0;

    always @(negedge clk) begin
        dn_rvalid = '0;
        dn_err = '0;
        if (pend) begin
            dn_rvalid[pend_port] = 1'b1;
            dn_rdata[pend_port*32 +: 32] = rd_pattern(pend_port, pend_addr);
            dn_err[pend_port] = (pend_port == ERR_PORT);
            pend = 0;
        end
        if (|dn_valid_o) begin
            dv_seen++;
            if (stall_cnt < stall_req) begin
                stall_cnt++;
                dn_ready = '0;
            end else begin
                dn_ready = '1;
                stall_cnt = 0;
                pend = 1;
                for (int k = 0; k < N; k++) if (dn_valid_o[k]) pend_port = k;
                pend_addr = dn_addr_o;
                seen_port = pend_port;
                seen_write = dn_write_o;
                seen_wdata = dn_wdata_o;
                fwd_count++;
            end
        end else begin
            dn_ready = (stall_req == 0) ? '1 : '0;
        end
    end

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        if (!rst) chk(irq_o === m_irq, "R12 irq equals flag and enable (model)", 32'(irq_o), 32'(m_irq));
    endtask

    task automatic txn(input int p, input bit wr, input bit sec, input bit usr,
                       input logic [11:0] a, input logic [31:0] wd, input int stall,
                       input bit ns_apply, input logic [N-1:0] ns_new, input string tag);
        int exp_v, fwd0, dv0, n;
        bit exp_es;
        stall_req = stall;
        tick();
        while (!up_ready_o) tick();
        exp_v = verdict(p, sec, usr);
        exp_es = m_err;
        if (ns_apply) ns_in = ns_new;
        up_valid = 1; up_port = 4'(p); up_write = wr; up_secure = sec; up_user = usr;
        up_addr = a; up_wdata = wd;
        fwd0 = fwd_count; dv0 = dv_seen;
        tick();
        up_valid = 0;
        if (exp_v != 0) begin
            chk(up_rvalid_o === 1'b1, {tag, " refused: response one cycle later"}, 32'(up_rvalid_o), 1);
            chk(up_err_o === ((exp_v == 2) ? 1'b1 : exp_es), {tag, " refused: error bit"},
                32'(up_err_o), (exp_v == 2) ? 1 : 32'(exp_es));
            chk(up_rdata_o === 32'h0, {tag, " refused: zero data"}, up_rdata_o, 0);
            chk(dv_seen == dv0, {tag, " refused: nothing downstream"}, 32'(dv_seen - dv0), 0);
        end else begin
            n = 0;
            chk(up_ready_o === 1'b0, {tag, " R13 busy after accept"}, 32'(up_ready_o), 0);
            while (!up_rvalid_o && n < 40) begin tick(); n++; end
            chk(up_rvalid_o === 1'b1, {tag, " R6 forwarded response arrives"}, 32'(up_rvalid_o), 1);
            chk(up_rdata_o === rd_pattern(p, a), {tag, " R6 read data from port"}, up_rdata_o, rd_pattern(p, a));
            chk(up_err_o === (p == ERR_PORT), {tag, " R6 port error passed up"}, 32'(up_err_o), 32'(p == ERR_PORT));
            chk(seen_port == p && seen_write == wr && (!wr || seen_wdata == wd),
                {tag, " R6 forwarded to selected port"}, 32'(seen_port), 32'(p));
            chk(fwd_count == fwd0 + 1, {tag, " R6 one downstream handshake"}, 32'(fwd_count - fwd0), 1);
            if (stall > 0)
                chk(dv_seen - dv0 == stall + 1, {tag, " R6 valid held through stall"},
                    32'(dv_seen - dv0), 32'(stall + 1));
        end
        stall_req = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(up_ready_o === 1'b1 && up_rvalid_o === 1'b0, "R1 idle handshake after reset",
            {30'd0, up_ready_o, up_rvalid_o}, 32'h2);
        chk(dn_valid_o === '0 && irq_o === 1'b0, "R1 no downstream valid, no irq after reset",
            {15'd0, irq_o, dn_valid_o}, 0);

        err_in = 1; en_in = 1;
        // all ports secure, no unprivileged access
        txn(1, 0, 1, 0, 12'h010, 0, 0, 0, '0, "R6 secure read port1");
        txn(1, 0, 0, 0, 12'h014, 0, 0, 0, '0, "R3 R7 nonsecure to secure port");
        tick();
        chk(irq_o === 1'b1, "R10 flag set by refusal", 32'(irq_o), 1);
        en_in = 0; tick(); tick();
        chk(irq_o === 1'b0, "R12 enable low masks irq", 32'(irq_o), 0);
        en_in = 1; tick(); tick();
        chk(irq_o === 1'b1, "R10 flag sticky", 32'(irq_o), 1);

        clr_in = 1; tick(); tick();
        chk(irq_o === 1'b0, "R11 clear wipes flag", 32'(irq_o), 0);
        txn(1, 1, 0, 0, 12'h020, 32'h1234, 0, 0, '0, "R11 refusal during clear");
        tick(); tick();
        chk(irq_o === 1'b0, "R11 refusal while clear held not recorded", 32'(irq_o), 0);
        clr_in = 0; tick(); tick();
        chk(irq_o === 1'b0, "R11 still clear after release", 32'(irq_o), 0);

        txn(3, 1, 0, 0, 12'h030, 32'hCAFE_0003, 0, 0, '0, "R4 masked port nonsecure write");
        txn(3, 0, 1, 0, 12'h034, 0, 0, 0, '0, "R4 masked port secure read");

        ns_in = 16'h0010; tick();
        txn(4, 0, 1, 0, 12'h040, 0, 0, 0, '0, "R3 secure to nonsecure port");
        txn(4, 0, 0, 0, 12'h044, 0, 0, 0, '0, "R3 nonsecure to nonsecure port");
        txn(4, 0, 0, 1, 12'h048, 0, 0, 0, '0, "R5 unprivileged refused");
        ap_in = 16'h0010; tick();
        txn(4, 1, 0, 1, 12'h04C, 32'h5555_AAAA, 0, 0, '0, "R5 unprivileged allowed");

        clr_in = 1; tick(); tick(); clr_in = 0; tick();
        err_in = 0; tick();
        txn(0, 0, 0, 0, 12'h050, 0, 0, 0, '0, "R8 silent read");
        txn(0, 1, 0, 0, 12'h054, 32'hDEAD_BEEF, 0, 0, '0, "R8 silent write");
        txn(5, 0, 1, 0, 12'h058, 0, 0, 0, '0, "R9 unconnected port with silent mode");
        clr_in = 1; tick(); tick(); clr_in = 0; tick(); tick();
        txn(5, 1, 1, 0, 12'h05C, 32'h1, 0, 0, '0, "R9 unconnected write");
        tick(); tick();
        chk(irq_o === 1'b0, "R9 unconnected access leaves flag clear", 32'(irq_o), 0);

        err_in = 1; tick();
        txn(2, 0, 1, 0, 12'h060, 0, 3, 0, '0, "R6 stalled port with error");
        // same-edge config change: old setting (port6 secure) judges a nonsecure access
        txn(6, 0, 0, 0, 12'h070, 0, 0, 1, 16'h0050, "R2 old setting refuses");
        txn(6, 0, 0, 0, 12'h074, 0, 0, 0, '0, "R2 new setting allows");
        tick(); tick();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule